// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block sits inside a memory controller and decides when the DRAM must get a refresh cycle. A single interval timer produces one tick per row period. Each tick creates a pending refresh. A row counter, a pending-request counter and a short cycle timer turn those pending refreshes into requests to the access arbiter. Once the arbiter accepts a request, the scheduler runs a refresh cycle that lasts a fixed number of clocks.

There are two policies, chosen by an input. In the spread-out policy, each tick adds one pending refresh, so single rows are refreshed in the gaps between normal accesses. In the batched policy, the scheduler counts ticks up to one full retention window (one tick per row). At the end of the window it queues a refresh for every row at once, and those refreshes run back to back. Row addressing also has two choices. The scheduler can drive the row number from its own counter, or it can only trigger the refresh and leave the row sequence to the device. A high-temperature flag halves the tick period. A self-refresh request hands refresh duty over to the device and silences the scheduler.

Top module: `rfsh_sched`

## Requirements
- R1: After reset, every output is low. The row counter starts at row 0 and the timer starts a full interval.
- R2: In the spread-out policy (`batch_mode_i`=0), with the high-temperature flag low, one refresh becomes pending every INTERVAL clocks. When the arbiter accepts at once, successive refresh cycles start exactly INTERVAL clocks apart.
- R3: While `hot_i` is high, the tick period is INTERVAL/2 clocks, and accepted refreshes start INTERVAL/2 clocks apart.
- R4: Each refresh cycle holds `ref_busy_o` high for exactly REF_CLKS consecutive clocks. The cycle starts on the clock edge after the request is accepted.
- R5: In counter-driven addressing (`own_row_i`=1, sampled when a cycle starts), `ref_row_en_o` is high during the cycle and `ref_row_o` carries the row number. The row advances by one when the cycle ends and wraps from N_ROWS-1 to 0.
- R6: In device-counted addressing (`own_row_i`=0), `ref_row_en_o` stays low and `ref_row_o` stays 0 during the cycle. The internal row counter does not advance, so the next counter-driven cycle reuses the row that would have come next.
- R7: A refresh request stays raised until it is accepted. A cycle starts only on a clock where `ref_ack_i` is high and `access_busy_i` is low, and never while another refresh cycle is running. Pending refreshes accumulate and saturate at N_ROWS.
- R8: `ref_urgent_o` is high exactly while more than URGENT_LIM refreshes are pending.
- R9: In the batched policy (`batch_mode_i`=1), nothing becomes pending on individual ticks. Every N_ROWS ticks, N_ROWS refreshes become pending together. When the arbiter accepts at once, their cycles start REF_CLKS+1 clocks apart. The first cycles of consecutive windows start N_ROWS*INTERVAL clocks apart.
- R10: While `self_ref_req_i` is high, no request is raised. After any running cycle ends, `self_ref_o` rises one clock later, pending refreshes are dropped and the timer is held. When the request falls, the timer restarts with a full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| batch_mode_i | input | 1 | 0: one row per tick; 1: all rows per window |
| own_row_i | input | 1 | 1: scheduler drives the row; 0: device counts rows |
| hot_i | input | 1 | High temperature, halves the tick period |
| self_ref_req_i | input | 1 | Hand refresh to the device (sleep) |
| ref_ack_i | input | 1 | Arbiter accepts the refresh request |
| access_busy_i | input | 1 | A normal access is in progress |
| ref_req_o | output | 1 | Refresh request to the arbiter |
| ref_urgent_o | output | 1 | Backlog above limit, refresh must win |
| ref_busy_o | output | 1 | Refresh cycle in progress |
| ref_row_o | output | $clog2(N_ROWS) | Row to refresh (counter-driven mode) |
| ref_row_en_o | output | 1 | `ref_row_o` is valid |
| self_ref_o | output | 1 | Device is in self-refresh |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that reset is held low for the first clocks. They also assume the arbiter's `access_busy_i` really marks the clocks where a normal access owns the device. With that, a cycle start can be traced back to an accept on a free clock. The stimulus holds `ref_ack_i` high except where it deliberately blocks with `access_busy_i`. It changes policy, temperature, addressing and self-refresh only on the clock right after a refresh cycle has started, when the backlog is empty. This keeps every expected start time computable. Refresh starts whose timing is disturbed by such a switch get only their row checked, not their spacing.

// File: rtl/rfsh_pkg.sv
// Shared types for the refresh scheduler.
package rfsh_pkg;
    // Refresh policy: single row per tick, or a full-window batch.
    typedef enum logic {
        POL_SPREAD = 1'b0,
        POL_BATCH  = 1'b1
    } policy_e;
endpackage

// File: rtl/rfsh_timer.sv
// Interval timer: emits one tick per row period, or per half period when hot.
// It also counts ticks into windows of N_ROWS and flags the last tick of each window.
// Assumes INTERVAL >= 4 so that the halved period is at least 2 clocks.
module rfsh_timer #(
    parameter int INTERVAL = 1040,
    parameter int N_ROWS   = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic hot_i,
    output logic tick_o,
    output logic win_tick_o
);
    localparam int CW   = $clog2(INTERVAL);
    localparam int WW   = (N_ROWS > 1) ? $clog2(N_ROWS) : 1;
    localparam int HALF = INTERVAL / 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;
    logic [WW-1:0] win;

    assign reload     = hot_i ? CW'(HALF - 1) : CW'(INTERVAL - 1);
    assign tick_o     = run_i && (cnt == '0);
    assign win_tick_o = tick_o && (win == WW'(N_ROWS - 1));

    // Count down; reload on expiry, while halted, or when the period shrinks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CW'(INTERVAL - 1);
        else if (!run_i || cnt == '0 || cnt > reload)
            cnt <= reload;
        else
            cnt <= cnt - 1'b1;
    end

    // Count ticks within one retention window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            win <= '0;
        else if (tick_o)
            win <= (win == WW'(N_ROWS - 1)) ? '0 : win + 1'b1;
    end

    // R2: ticks are never on adjacent clocks.
    assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/rfsh_pending.sv
// Pending-refresh counter: adds per tick or per window, subtracts one per start.
// Saturates at N_ROWS and flags a backlog above URGENT_LIM.
module rfsh_pending
    import rfsh_pkg::*;
#(
    parameter int N_ROWS     = 8192,
    parameter int URGENT_LIM = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear_i,
    input  policy_e policy_i,
    input  logic    tick_i,
    input  logic    win_tick_i,
    input  logic    take_i,
    output logic    pend_any_o,
    output logic    urgent_o
);
    localparam int PW = $clog2(N_ROWS + 1);

    logic [PW-1:0] pend;
    logic [PW-1:0] add;
    logic [PW-1:0] room;
    logic [PW-1:0] add_eff;

    // Select how many refreshes this clock contributes.
    always_comb begin
        if (policy_i == POL_BATCH)
            add = win_tick_i ? PW'(N_ROWS) : '0;
        else
            add = tick_i ? PW'(1) : '0;
        room    = PW'(N_ROWS) - pend;
        add_eff = (add > room) ? room : add;
    end

    // Update the backlog; dropped entirely while the device self-refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            pend <= '0;
        else
            pend <= pend + add_eff - PW'(take_i);
    end

    assign pend_any_o = (pend != '0);
    assign urgent_o   = (pend > PW'(URGENT_LIM));

    // R7: backlog never exceeds one window's worth of rows.
    assert_pend_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PW'(N_ROWS));
    // R8: urgency can only appear right after refreshes were added.
    assert_urgent_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(urgent_o) |-> $past(tick_i || win_tick_i));
endmodule

// File: rtl/rfsh_cycle.sv
// Refresh cycle sequencer and row counter.
// Runs one REF_CLKS-long cycle per start. Latches the addressing choice at the start
// and advances the row at the end only for counter-driven cycles.
// Assumes start_i is only asserted while no cycle runs.
module rfsh_cycle #(
    parameter int N_ROWS   = 8192,
    parameter int REF_CLKS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      own_row_i,
    output logic                      busy_o,
    output logic [$clog2(N_ROWS)-1:0] row_o,
    output logic                      row_en_o
);
    localparam int RW  = $clog2(N_ROWS);
    localparam int CCW = (REF_CLKS > 1) ? $clog2(REF_CLKS) : 1;

    logic           active;
    logic [CCW-1:0] cyc;
    logic           own_q;
    logic [RW-1:0]  row;
    logic           last;

    assign last = active && (cyc == '0);

    // Sequence the fixed-length cycle and latch the addressing choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cyc    <= '0;
            own_q  <= 1'b0;
        end else if (start_i) begin
            active <= 1'b1;
            cyc    <= CCW'(REF_CLKS - 1);
            own_q  <= own_row_i;
        end else if (last) begin
            active <= 1'b0;
        end else if (active) begin
            cyc <= cyc - 1'b1;
        end
    end

    // Advance the row after each counter-driven cycle, wrapping at the last row.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row <= '0;
        else if (last && own_q)
            row <= (row == RW'(N_ROWS - 1)) ? '0 : row + 1'b1;
    end

    assign busy_o   = active;
    assign row_en_o = active && own_q;
    assign row_o    = row_en_o ? row : '0;

    // R5: the row after the last one is row 0.
    assert_row_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (last && own_q && row == RW'(N_ROWS - 1)) |=> (row == '0));
    // R7: a new cycle never starts inside a running one.
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !active);
endmodule

// File: rtl/rfsh_sched.sv
// DRAM refresh scheduler top.
// Ties the timer, backlog and cycle sequencer together. It raises requests to the
// access arbiter and starts a refresh only on an accept during a free clock.
// It yields to device self-refresh on request.
// Assumes all inputs are synchronous to clk.
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int N_ROWS     = 8192,
    parameter int INTERVAL   = 1040,
    parameter int REF_CLKS   = 4,
    parameter int URGENT_LIM = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      batch_mode_i,
    input  logic                      own_row_i,
    input  logic                      hot_i,
    input  logic                      self_ref_req_i,
    input  logic                      ref_ack_i,
    input  logic                      access_busy_i,
    output logic                      ref_req_o,
    output logic                      ref_urgent_o,
    output logic                      ref_busy_o,
    output logic [$clog2(N_ROWS)-1:0] ref_row_o,
    output logic                      ref_row_en_o,
    output logic                      self_ref_o
);
    logic    sleep;
    logic    tick;
    logic    win_tick;
    logic    pend_any;
    logic    start;
    policy_e policy;

    assign policy    = policy_e'(batch_mode_i);
    assign ref_req_o = pend_any && !ref_busy_o && !sleep && !self_ref_req_i;
    assign start     = ref_req_o && ref_ack_i && !access_busy_i;
    assign self_ref_o = sleep;

    // Enter self-refresh once no cycle is running; leave as soon as released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sleep <= 1'b0;
        else
            sleep <= self_ref_req_i && !ref_busy_o;
    end

    rfsh_timer #(.INTERVAL(INTERVAL), .N_ROWS(N_ROWS)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (!sleep),
        .hot_i      (hot_i),
        .tick_o     (tick),
        .win_tick_o (win_tick)
    );

    rfsh_pending #(.N_ROWS(N_ROWS), .URGENT_LIM(URGENT_LIM)) i_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (sleep),
        .policy_i   (policy),
        .tick_i     (tick),
        .win_tick_i (win_tick),
        .take_i     (start),
        .pend_any_o (pend_any),
        .urgent_o   (ref_urgent_o)
    );

    rfsh_cycle #(.N_ROWS(N_ROWS), .REF_CLKS(REF_CLKS)) i_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .own_row_i (own_row_i),
        .busy_o    (ref_busy_o),
        .row_o     (ref_row_o),
        .row_en_o  (ref_row_en_o)
    );

    // R7: every cycle start follows an accept on a clock free of normal access.
    assert_start_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_busy_o) |-> $past(ref_ack_i && !access_busy_i));
    // R10: self-refresh is entered only on request and never mid-cycle.
    assert_sleep_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(self_ref_o) |-> $past(self_ref_req_i && !ref_busy_o));
endmodule

// File: tb/test_rfsh_sched.sv
// Scoreboard bench: the driver queues expected refresh starts, the monitor
// pops one per observed start and compares row, addressing and spacing.
module test_rfsh_sched;
    localparam int N_ROWS = 8, INTERVAL = 20, REF_CLKS = 4, URGENT_LIM = 2;

    typedef struct {
        int    row;
        bit    own;
        int    gap;
        string tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic batch_mode_i = 1'b0, own_row_i = 1'b1, hot_i = 1'b0;
    logic self_ref_req_i = 1'b0, ref_ack_i = 1'b1, access_busy_i = 1'b0;
    logic ref_req_o, ref_urgent_o, ref_busy_o, ref_row_en_o, self_ref_o;
    logic [2:0] ref_row_o;

    int checks = 0, errors = 0, cyc_now = 0, last_start = 0, width = 0;
    bit busy_prev = 1'b0, done = 1'b0;
    exp_t q[$];
    event popped_ev;

    rfsh_sched #(.N_ROWS(N_ROWS), .INTERVAL(INTERVAL), .REF_CLKS(REF_CLKS),
                 .URGENT_LIM(URGENT_LIM)) i_rfsh_sched (
        .clk(clk), .rst_n(rst_n), .batch_mode_i(batch_mode_i), .own_row_i(own_row_i),
        .hot_i(hot_i), .self_ref_req_i(self_ref_req_i), .ref_ack_i(ref_ack_i),
        .access_busy_i(access_busy_i), .ref_req_o(ref_req_o), .ref_urgent_o(ref_urgent_o),
        .ref_busy_o(ref_busy_o), .ref_row_o(ref_row_o), .ref_row_en_o(ref_row_en_o),
        .self_ref_o(self_ref_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc_now++;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc_now);
        end
    endtask

    task automatic push(int row, bit own, int gap, string tag);
        exp_t e;
        e.row = row; e.own = own; e.gap = gap; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drain();
        while (q.size() != 0) @(popped_ev);
    endtask

    // Monitor: compare each observed cycle start against the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ref_busy_o && !busy_prev) begin
                int gap;
                gap = cyc_now - last_start;
                last_start = cyc_now;
                width = 1;
                if (q.size() == 0) begin
                    chk(1'b0, "R7 unexpected refresh start", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(ref_row_en_o == e.own, "R6 row enable", ref_row_en_o, e.own);
                    if (e.own) chk(ref_row_o == 3'(e.row), "R5 row", ref_row_o, e.row);
                    else       chk(ref_row_o == 3'd0, "R6 row held at 0", ref_row_o, 0);
                    if (e.gap != 0) chk(gap == e.gap, e.tag, gap, e.gap);
                    ->popped_ev;
                end
            end else if (ref_busy_o) begin
                width++;
            end else if (busy_prev) begin
                chk(width == REF_CLKS, "R4 cycle length", width, REF_CLKS);
            end
        end
        busy_prev = ref_busy_o;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!ref_req_o && !ref_busy_o && !ref_urgent_o && !ref_row_en_o && !self_ref_o,
            "R1 outputs in reset", {ref_req_o, ref_busy_o, ref_urgent_o, ref_row_en_o, self_ref_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ref_req_o && !ref_busy_o && !self_ref_o, "R1 outputs after reset",
            {ref_req_o, ref_busy_o, self_ref_o}, 0);

        // Spread-out policy, counter addressing, row wrap.
        push(0, 1, 0, "R2 spacing");
        for (int i = 1; i < 10; i++) push(i % N_ROWS, 1, INTERVAL, "R2 spacing");
        drain();

        // High temperature halves the spacing.
        hot_i = 1'b1;
        push(2, 1, 0, "R3 spacing");
        for (int i = 3; i < 6; i++) push(i, 1, INTERVAL / 2, "R3 spacing");
        drain();

        // Device-counted addressing leaves the row counter alone.
        hot_i = 1'b0; own_row_i = 1'b0;
        push(0, 0, 0, "R6 spacing");
        push(0, 0, INTERVAL, "R6 spacing");
        push(0, 0, INTERVAL, "R6 spacing");
        drain();
        own_row_i = 1'b1;
        push(6, 1, INTERVAL, "R6 spacing");
        push(7, 1, INTERVAL, "R6 spacing");
        drain();

        // Normal access blocks the start; backlog builds to 3 and goes urgent.
        access_busy_i = 1'b1;
        repeat (65) @(negedge clk);
        chk(ref_req_o, "R7 request held", ref_req_o, 1);
        chk(!ref_busy_o, "R7 no start during access", ref_busy_o, 0);
        chk(ref_urgent_o, "R8 urgent above limit", ref_urgent_o, 1);
        push(0, 1, 0, "R7 backlog spacing");
        for (int i = 1; i < 4; i++) push(i, 1, REF_CLKS + 1, "R7 backlog spacing");
        access_busy_i = 1'b0;
        drain();
        chk(!ref_urgent_o, "R8 urgent cleared", ref_urgent_o, 0);

        // Batched policy: two full windows.
        batch_mode_i = 1'b1;
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < N_ROWS; i++)
                push((4 + i) % N_ROWS, 1,
                     (i != 0) ? REF_CLKS + 1 :
                     (w == 0) ? 0 : N_ROWS * INTERVAL - (N_ROWS - 1) * (REF_CLKS + 1),
                     "R9 spacing");
        drain();

        // Self-refresh hand-over.
        batch_mode_i = 1'b0; self_ref_req_i = 1'b1;
        repeat (10) @(negedge clk);
        chk(self_ref_o, "R10 self-refresh entered", self_ref_o, 1);
        chk(!ref_req_o, "R10 no request", ref_req_o, 0);
        repeat (100) @(negedge clk);
        chk(self_ref_o && !ref_req_o, "R10 quiet while asleep", {self_ref_o, ref_req_o}, 2);
        self_ref_req_i = 1'b0;
        @(negedge clk);
        chk(!self_ref_o, "R10 self-refresh left", self_ref_o, 0);
        push(4, 1, 0, "R10 resume");
        push(5, 1, INTERVAL, "R10 resume");
        drain();
        repeat (10) @(negedge clk);
        chk(q.size() == 0, "R2 queue empty", q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", q.size(), 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule